// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs register accesses to an Ethernet PHY over the two-wire management bus. A host pulses `start` together with a read/write selector, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then sends one complete frame on `mdc` and the split MDIO pin (`mdio_o`, `mdio_oe`, `mdio_i`) and raises `done` for one clock when the frame is over. After a read, `rd_data` holds the returned word.

Every frame opens with a run of ones, then a start pattern, an opcode and the two addresses. On a read, the block releases the line for the turnaround and checks that the PHY answers by pulling that bit low. If nothing answers, the line stays high. The block then clocks a further flush run with the line released, and ends with `err` set instead of taking data. After a write, the line is released for one final MDC cycle. The MDC half-period is a parameter `MDC_HALF`, counted in system clocks, with a minimum of 1.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no frame is in progress, `mdc` is 0, `mdio_oe` is 0, `mdio_o` is 0 and `done` is 0. Reset also clears `err` and `rd_data` to 0.
- R2: A frame begins with 32 MDC cycles, during which MDIO is driven (`mdio_oe`=1) with the value 1.
- R3: After the preamble, 14 driven bits follow in this order: 0, 1, then the opcode (1,0 for a read and 0,1 for a write), then the PHY address MSB first, then the register address MSB first.
- R4: Every low phase and every high phase of `mdc` lasts exactly `MDC_HALF` clocks. `mdio_o` and `mdio_oe` change only on the clock edge on which `mdc` falls, so both are steady across each rising edge.
- R5: On a read (`op_read`=1), the next MDC cycle after the header has MDIO released. `mdio_i` is sampled on the last clock of its high phase. If that sample is 0, 16 more released cycles follow, each sampled at the end of its high phase, and the samples are assembled MSB first into `rd_data`. While `mdio_oe` is 0, `mdio_o` is 0.
- R6: A successful read adds two more released MDC cycles after the 16th data cycle and then finishes with `err`=0.
- R7: If the turnaround sample of a read is 1, the block clocks 32 further MDC cycles with MDIO released and then finishes with `err`=1. `rd_data` keeps its previous value.
- R8: On a write (`op_read`=0), the two turnaround cycles are driven as 1 and then 0, followed by `wr_data` as 16 driven bits MSB first.
- R9: After the last write bit, MDIO is released for one further MDC cycle and the frame then finishes with `err`=0. `rd_data` is unchanged by a write.
- R10: `done` is high for exactly one clock per frame, on the clock after the edge that ends the last high phase, and `mdc` is already low in that clock. `err` is valid from that clock and holds until the next frame finishes.
- R11: A `start` pulse that arrives while a frame is in progress is ignored. The frame in progress continues unchanged, and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a frame; taken only when idle |
| op_read | input | 1 | 1 = read, 0 = write; sampled with start |
| phy_addr | input | 5 | PHY address; sampled with start |
| reg_addr | input | 5 | Register address; sampled with start |
| wr_data | input | 16 | Write value; sampled with start |
| rd_data | output | 16 | Word assembled by the last successful read |
| done | output | 1 | One-clock pulse at the end of a frame |
| err | output | 1 | Last read saw no turnaround response |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value from the pad |

## Verification
The bench builds the block with `MDC_HALF` set to 3. Each phase therefore spans several clocks, so a counter that ends a phase one clock early or late, or an MDIO change made inside a high phase, shows up at a specific clock. The preamble and flush lengths keep their default of 32. The bench's PHY model can be told to leave the turnaround high, which takes the block into the flush and error path, and it can inject a `start` pulse in the middle of a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Sequencer phases of one management frame.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_HDR,
    PH_TA,
    PH_DATA,
    PH_TAIL,
    PH_FLUSH
  } mdio_phase_e;

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic half_end
);

  generate
    if (HALF <= 1) begin : g_every_clk
      // A one-clock half-period needs no counter.
      assign half_end = run;
    end else begin : g_count
      localparam int CW = $clog2(HALF);
      localparam logic [CW-1:0] LAST = CW'(HALF - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || !run) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      assign half_end = run && (cnt == LAST);
    end
  endgenerate

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN   = 32,
  parameter int FLUSH_LEN = 32,
  parameter int AW        = 5,
  parameter int DW        = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_read,
  input  logic [AW-1:0] phy_addr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          half_end,
  input  logic          mdio_i,
  output logic          active,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data
);

  localparam int HDR_LEN = 4 + 2 * AW;
  localparam int M1      = (PRE_LEN > FLUSH_LEN) ? PRE_LEN : FLUSH_LEN;
  localparam int M2      = (DW > HDR_LEN) ? DW : HDR_LEN;
  localparam int MAXL    = (M1 > M2) ? M1 : M2;
  localparam int CNT_W   = $clog2(MAXL + 1);

  mdio_phase_e          phase;
  logic [CNT_W-1:0]     cnt;
  logic                 is_rd;
  logic [HDR_LEN-1:0]   hdr_sr;
  logic [DW-1:0]        dat_sr;
  logic                 mdc_q, oe_q, o_q, done_q, err_q;
  logic [DW-1:0]        rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      is_rd  <= 1'b0;
      hdr_sr <= '0;
      dat_sr <= '0;
      mdc_q  <= 1'b0;
      oe_q   <= 1'b0;
      o_q    <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase  <= PH_PRE;
          cnt    <= '0;
          is_rd  <= op_read;
          hdr_sr <= {2'b01, (op_read ? 2'b10 : 2'b01), phy_addr, reg_addr};
          dat_sr <= op_read ? '0 : wr_data;
          mdc_q  <= 1'b0;
          oe_q   <= 1'b1;
          o_q    <= 1'b1;
        end
      end else if (half_end) begin
        if (!mdc_q) begin
          // end of low phase
          mdc_q <= 1'b1;
        end else begin
          // end of high phase: slot complete, set up the next one
          mdc_q <= 1'b0;
          case (phase)
            PH_PRE: begin
              if (cnt == CNT_W'(PRE_LEN - 1)) begin
                phase  <= PH_HDR;
                cnt    <= '0;
                o_q    <= hdr_sr[HDR_LEN-1];
                hdr_sr <= {hdr_sr[HDR_LEN-2:0], 1'b0};
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            PH_HDR: begin
              if (cnt == CNT_W'(HDR_LEN - 1)) begin
                phase <= PH_TA;
                cnt   <= '0;
                oe_q  <= !is_rd;
                o_q   <= !is_rd;
              end else begin
                cnt    <= cnt + 1'b1;
                o_q    <= hdr_sr[HDR_LEN-1];
                hdr_sr <= {hdr_sr[HDR_LEN-2:0], 1'b0};
              end
            end
            PH_TA: begin
              if (is_rd) begin
                cnt   <= '0;
                phase <= mdio_i ? PH_FLUSH : PH_DATA;
              end else if (cnt == '0) begin
                cnt <= CNT_W'(1);
                o_q <= 1'b0;
              end else begin
                phase  <= PH_DATA;
                cnt    <= '0;
                o_q    <= dat_sr[DW-1];
                dat_sr <= {dat_sr[DW-2:0], 1'b0};
              end
            end
            PH_DATA: begin
              if (is_rd) begin
                dat_sr <= {dat_sr[DW-2:0], mdio_i};
              end
              if (cnt == CNT_W'(DW - 1)) begin
                phase <= PH_TAIL;
                cnt   <= '0;
                oe_q  <= 1'b0;
                o_q   <= 1'b0;
              end else begin
                cnt <= cnt + 1'b1;
                if (!is_rd) begin
                  o_q    <= dat_sr[DW-1];
                  dat_sr <= {dat_sr[DW-2:0], 1'b0};
                end
              end
            end
            PH_TAIL: begin
              if (cnt == (is_rd ? CNT_W'(1) : CNT_W'(0))) begin
                phase  <= PH_IDLE;
                done_q <= 1'b1;
                err_q  <= 1'b0;
                if (is_rd) begin
                  rd_q <= dat_sr;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            PH_FLUSH: begin
              if (cnt == CNT_W'(FLUSH_LEN - 1)) begin
                phase  <= PH_IDLE;
                done_q <= 1'b1;
                err_q  <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  assign active  = (phase != PH_IDLE);
  assign mdc     = mdc_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign done    = done_q;
  assign err     = err_q;
  assign rd_data = rd_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int MDC_HALF  = 4,
  parameter int PRE_LEN   = 32,
  parameter int FLUSH_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        op_read,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        done,
  output logic        err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int AW = 5;
  localparam int DW = 16;

  logic run;
  logic half_end;

  mdio_half_timer #(.HALF(MDC_HALF)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .half_end (half_end)
  );

  mdio_frame_seq #(
    .PRE_LEN   (PRE_LEN),
    .FLUSH_LEN (FLUSH_LEN),
    .AW        (AW),
    .DW        (DW)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .op_read  (op_read),
    .phy_addr (phy_addr),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .half_end (half_end),
    .mdio_i   (mdio_i),
    .active   (run),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (done),
    .err      (err),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF = 4
) (
  input logic clk,
  input logic rst,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);

  // Clocks seen with mdc high since its last rise.
  int hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= 0;
    end else if ($rose(mdc)) begin
      hi_cnt <= 1;
    end else if (mdc) begin
      hi_cnt <= hi_cnt + 1;
    end
  end

  // R4: pin value and enable move only together with a falling mdc
  a_r4_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);

  // R4: rising mdc never coincides with a data change
  a_r4_held_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R4: high phase width
  a_r4_high_width: assert property (@(posedge clk) disable iff (rst)
    $fell(mdc) |-> (hi_cnt == HALF));

  // R10: done is a single-clock pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: bus is quiet when the frame ends
  a_r1_quiet_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mdc && !mdio_oe));

  // R5: released line carries a zero output value
  a_r5_released_zero: assert property (@(posedge clk) disable iff (rst)
    !mdio_oe |-> !mdio_o);

endmodule

bind mdio_master mdio_master_chk #(.HALF(MDC_HALF)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .done    (done),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;

  localparam int HALF  = 3;
  localparam int LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op_read = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        done, err, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;
  logic [15:0] last_rd = '0;

  // expected half-period stream: {mdc, oe, o}, region, PHY drive
  logic [2:0] exp_q[$];
  int         reg_q[$];
  bit         drv_q[$];

  always #10 clk = ~clk;

  mdio_master #(.MDC_HALF(HALF)) u0 (
    .clk(clk), .rst(rst), .start(start), .op_read(op_read),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .done(done), .err(err), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT && !finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=%0d expected=<%0d", cyc, LIMIT);
      summary();
    end
  end

  task automatic push_slot(input bit oe, input bit o, input int rg, input bit drv);
    exp_q.push_back({1'b0, oe, o}); reg_q.push_back(rg); drv_q.push_back(drv);
    exp_q.push_back({1'b1, oe, o}); reg_q.push_back(rg); drv_q.push_back(drv);
  endtask

  function automatic string rtag(int r, bit rd, bit ok);
    case (r)
      0: return "R2 R4 preamble";
      1: return "R3 R4 header";
      2: return rd ? "R5 read turnaround/data" : "R8 write turnaround/data";
      default: return rd ? (ok ? "R6 read tail" : "R7 flush run") : "R9 write release";
    endcase
  endfunction

  task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input bit ta_ok,
                         input logic [15:0] phy_word, input bit poke);
    logic [13:0] hdr;
    int mis[4];
    logic [2:0] fa[4];
    logic [2:0] fe[4];
    logic [2:0] act;
    int quiet_bad;
    exp_q.delete(); reg_q.delete(); drv_q.delete();
    for (int r = 0; r < 4; r++) begin mis[r] = 0; fa[r] = '0; fe[r] = '0; end
    hdr = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
    for (int i = 0; i < 32; i++) push_slot(1, 1, 0, 1);
    for (int i = 0; i < 14; i++) push_slot(1, hdr[13-i], 1, 1);
    if (rd) begin
      push_slot(0, 0, 2, !ta_ok);
      if (ta_ok) begin
        for (int i = 0; i < 16; i++) push_slot(0, 0, 2, phy_word[15-i]);
        for (int i = 0; i < 2; i++) push_slot(0, 0, 3, 1);
      end else begin
        for (int i = 0; i < 32; i++) push_slot(0, 0, 3, 1);
      end
    end else begin
      push_slot(1, 1, 2, 1);
      push_slot(1, 0, 2, 1);
      for (int i = 0; i < 16; i++) push_slot(1, wd[15-i], 2, 1);
      push_slot(0, 0, 3, 1);
    end
    op_read = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
    start = 1'b1;
    for (int h = 0; h < exp_q.size(); h++) begin
      for (int c = 0; c < HALF; c++) begin
        @(negedge clk);
        if (h == 0 && c == 0) start = 1'b0;
        if (c == 0) mdio_i = drv_q[h];
        if (poke && h == 40) begin
          start = (c == 0);
          op_read = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
        end
        act = {mdc, mdio_oe, mdio_o};
        if (act !== exp_q[h]) begin
          if (mis[reg_q[h]] == 0) begin fa[reg_q[h]] = act; fe[reg_q[h]] = exp_q[h]; end
          mis[reg_q[h]]++;
        end
      end
    end
    for (int r = 0; r < 4; r++) chk(mis[r] == 0, rtag(r, rd, ta_ok), {29'd0, fa[r]}, {29'd0, fe[r]});
    @(negedge clk);
    mdio_i = 1'b1;
    chk(done === 1'b1, "R10 done at frame end", {31'd0, done}, 32'd1);
    chk({mdc, mdio_oe, mdio_o} === 3'b000, "R1 bus quiet after frame", {29'd0, mdc, mdio_oe, mdio_o}, 32'd0);
    chk(err === (rd && !ta_ok), rd ? (ta_ok ? "R6 err clear after read" : "R7 err set") : "R9 err clear after write",
        {31'd0, err}, {31'd0, (rd && !ta_ok)});
    if (rd && ta_ok) last_rd = phy_word;
    chk(rd_data === last_rd, rd ? (ta_ok ? "R5 read word" : "R7 read data kept") : "R9 read data kept",
        {16'd0, rd_data}, {16'd0, last_rd});
    @(negedge clk);
    chk(done === 1'b0, "R10 done single clock", {31'd0, done}, 32'd0);
    chk(err === (rd && !ta_ok), "R10 err held", {31'd0, err}, {31'd0, (rd && !ta_ok)});
    if (poke) begin
      quiet_bad = 0;
      for (int i = 0; i < 4 * HALF; i++) begin
        @(negedge clk);
        if (mdc !== 1'b0 || mdio_oe !== 1'b0 || done !== 1'b0) quiet_bad++;
      end
      chk(quiet_bad == 0, "R11 no frame from mid-frame start", quiet_bad, 0);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mdc === 1'b0, "R1 reset mdc", {31'd0, mdc}, 0);
    chk(mdio_oe === 1'b0 && mdio_o === 1'b0, "R1 reset mdio", {30'd0, mdio_oe, mdio_o}, 0);
    chk(done === 1'b0, "R1 reset done", {31'd0, done}, 0);
    chk(err === 1'b0, "R1 reset err", {31'd0, err}, 0);
    chk(rd_data === 16'h0, "R1 reset rd_data", {16'd0, rd_data}, 0);
    run_txn(1'b1, 5'h01, 5'h02, 16'h0000, 1'b1, 16'hA5C3, 1'b0);
    run_txn(1'b0, 5'h1F, 5'h00, 16'h8001, 1'b1, 16'h0000, 1'b0);
    run_txn(1'b1, 5'h1F, 5'h1F, 16'h0000, 1'b1, 16'h0001, 1'b0);
    run_txn(1'b1, 5'h05, 5'h11, 16'h0000, 1'b0, 16'hFFFF, 1'b0);
    run_txn(1'b1, 5'h0A, 5'h15, 16'h0000, 1'b1, 16'h7E18, 1'b0);
    run_txn(1'b0, 5'h12, 5'h0C, 16'h3C5A, 1'b1, 16'h0000, 1'b1);
    run_txn(1'b1, 5'h00, 5'h03, 16'h0000, 1'b1, 16'hC0DE, 1'b1);
    finished = 1;
    summary();
  end

endmodule